// File: doc/BRIEF.md
# Stepped Soft-Start and Power-Good Sequencer

This block sets the order of events when a synchronous buck controller starts. Startup begins when the bias supply is above its lockout threshold and the converter is enabled. The block then counts switching cycles, one pulse of `cyc_strobe` per cycle. The count runs through four equal phases, and the phase sets the current-limit scale that the valley current comparator uses.

In the first phase the block also asks for a doubled minimum off-time, and it raises a positive offset for the on-time one-shot. The first switching action after release has to be a low-side pulse, which charges the bootstrap capacitor, so the block flags it. When the last phase ends, the block turns on the under-voltage and power-good supervision.

The block also drives power good. Power good stays low until soft-start has ended and the output has reached 90% of its setpoint. After that it follows the output regulation window. Every transition of power good is filtered by a fixed deglitch delay, counted in clock cycles. Losing the supply or the enable clears all state at once, and the sequence then restarts from the first phase.

Top module: `ss_pg_sequencer`

## Requirements
- R1: While `supply_ok` and `en` are not both high, every output is cleared on the next clock edge: `ilim_pct` is 0, and all flags and `pgood` are 0.
- R2: On the first clock edge at which `supply_ok` and `en` are both high, `ilim_pct` becomes 25, and `toff_double` and `ton_offset` become 1.
- R3: Each phase lasts 110 strobes. `ilim_pct` gives the scale in whole percent (unsigned, 7 bits): 25 in phase 1, 50 in phase 2, 75 in phase 3 and 100 in phase 4. It steps up on the clock edge that samples the 110th, 220th and 330th strobe.
- R4: `toff_double` and `ton_offset` are 1 only during phase 1. Both fall on the edge that samples the 110th strobe.
- R5: `first_low_pulse` goes to 1 when startup begins. It returns to 0 on the edge that samples the first strobe.
- R6: `sup_en` rises on the edge that samples the 440th strobe. After that, `sup_en` stays at 1 and `ilim_pct` stays at 100 for as long as the block is active, however many more strobes arrive.
- R7: `pgood` can go high only when `sup_en` is 1 and `at_90pct` is 1, with `win_over` and `win_under` both 0. Before `sup_en`, `pgood` stays low even when the output is good.
- R8: Once startup is over, `pgood` goes low when `win_over` or `win_under` stays high. It goes high again when both return to 0.
- R9: `pgood` changes only after its qualifying condition has held at a new value for `PG_DELAY_CLKS` clock edges in a row (default 500, which is 5 µs at 100 MHz). A shorter excursion leaves `pgood` unchanged.
- R10: When activation is lost, `pgood` drops on the next edge and the phase count is reset. When the block is activated again, it restarts from phase 1, with the first low-side pulse flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_strobe | input | 1 | One-clock pulse per switching cycle |
| supply_ok | input | 1 | Bias supply is above the lockout threshold |
| en | input | 1 | Converter enable |
| win_over | input | 1 | Output is above the upper power-good limit (+16%) |
| win_under | input | 1 | Output is below the lower power-good limit (-10%) |
| at_90pct | input | 1 | Output has reached 90% of its setpoint |
| ilim_pct | output | 7 | Current-limit scale, in percent |
| toff_double | output | 1 | Doubled minimum off-time requested |
| ton_offset | output | 1 | Startup offset for the on-time generator |
| first_low_pulse | output | 1 | Next switching action must be a low-side pulse |
| sup_en | output | 1 | Under-voltage and power-good supervision enabled |
| pgood | output | 1 | Filtered power-good output |

## Verification
The assertions assume that `cyc_strobe` is a single-clock pulse with at least one idle clock between pulses. They also assume that the window bits agree with each other: `win_under` is never high while `at_90pct` is high. The stimulus raises the strobe for one clock and then holds it low for one clock. It moves the window bits only as consistent pairs. The deglitch checks sample two clocks on each side of the nominal switching edge. This keeps them independent of the exact counter phase.

// File: rtl/ss_pkg.sv
package ss_pkg;
  localparam int PCT_W = 7;

  // Current-limit scale in percent for phase index idx of n phases.
  function automatic logic [PCT_W-1:0] phase_pct(input int idx, input int n);
    int v;
    v = ((idx + 1) * 100) / n;
    return PCT_W'(v);
  endfunction
endpackage

// File: rtl/ss_step_seq.sv
module ss_step_seq
  import ss_pkg::*;
#(
  parameter int STEP_CYCLES = 110,
  parameter int NUM_STEPS   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             strobe,
  output logic [PCT_W-1:0] pct,
  output logic             phase1,
  output logic             first_low,
  output logic             done
);
  localparam int CNT_W  = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam int STEP_W = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(STEP_CYCLES - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NUM_STEPS - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [STEP_W-1:0] idx_q, idx_d;
  logic              done_q, done_d;
  logic              seen_q, seen_d;

  always_comb begin
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    done_d = done_q;
    seen_d = seen_q;
    if (strobe) begin
      seen_d = 1'b1;
      if (!done_q) begin
        if (cnt_q == CNT_LAST) begin
          cnt_d = '0;
          if (idx_q == STEP_LAST) done_d = 1'b1;
          else                    idx_d  = idx_q + 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q     <= '0;
      idx_q     <= '0;
      done_q    <= 1'b0;
      seen_q    <= 1'b0;
      pct       <= '0;
      phase1    <= 1'b0;
      first_low <= 1'b0;
      done      <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      idx_q     <= idx_d;
      done_q    <= done_d;
      seen_q    <= seen_d;
      pct       <= phase_pct(int'(idx_d), NUM_STEPS);
      phase1    <= (idx_d == '0) && !done_d;
      first_low <= !seen_d;
      done      <= done_d;
    end
  end
endmodule

// File: rtl/pg_filter.sv
module pg_filter #(
  parameter int DELAY_CLKS = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic raw,
  output logic filt
);
  localparam int DW = $clog2(DELAY_CLKS + 1);
  localparam logic [DW-1:0] D_LAST = DW'(DELAY_CLKS - 1);

  logic [DW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      run_q <= '0;
      filt  <= 1'b0;
    end else if (raw != filt) begin
      if (run_q == D_LAST) begin
        filt  <= raw;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end
endmodule

// File: rtl/ss_pg_sequencer.sv
module ss_pg_sequencer
  import ss_pkg::*;
#(
  parameter int STEP_CYCLES   = 110,
  parameter int NUM_STEPS     = 4,
  parameter int PG_DELAY_CLKS = 500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_strobe,
  input  logic             supply_ok,
  input  logic             en,
  input  logic             win_over,
  input  logic             win_under,
  input  logic             at_90pct,
  output logic [PCT_W-1:0] ilim_pct,
  output logic             toff_double,
  output logic             ton_offset,
  output logic             first_low_pulse,
  output logic             sup_en,
  output logic             pgood
);
  logic active;
  logic phase1;
  logic pg_raw;

  assign active = supply_ok && en;

  ss_step_seq #(
    .STEP_CYCLES(STEP_CYCLES),
    .NUM_STEPS  (NUM_STEPS)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .strobe   (cyc_strobe),
    .pct      (ilim_pct),
    .phase1   (phase1),
    .first_low(first_low_pulse),
    .done     (sup_en)
  );

  assign toff_double = phase1;
  assign ton_offset  = phase1;
  assign pg_raw      = sup_en && at_90pct && !win_over && !win_under;

  pg_filter #(
    .DELAY_CLKS(PG_DELAY_CLKS)
  ) u_pg (
    .clk  (clk),
    .rst  (rst),
    .clear(!active),
    .raw  (pg_raw),
    .filt (pgood)
  );
endmodule

// File: rtl/ss_pg_sequencer_chk.sv
module ss_pg_sequencer_chk #(
  parameter int NUM_STEPS = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       supply_ok,
  input logic       en,
  input logic       win_over,
  input logic       win_under,
  input logic       at_90pct,
  input logic [6:0] ilim_pct,
  input logic       toff_double,
  input logic       first_low_pulse,
  input logic       sup_en,
  input logic       pgood
);
  localparam logic [6:0] FIRST_PCT = 7'((100) / NUM_STEPS);

  // R1
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !(supply_ok && en) |=> (ilim_pct == 7'd0) && !pgood && !sup_en);

  // R4
  toff_first_phase_chk: assert property (@(posedge clk) disable iff (rst)
    toff_double |-> (ilim_pct == FIRST_PCT) && !sup_en);

  // R5
  first_pulse_phase_chk: assert property (@(posedge clk) disable iff (rst)
    first_low_pulse |-> (ilim_pct == FIRST_PCT));

  // R6
  sup_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (sup_en && supply_ok && en) |=> sup_en && (ilim_pct == 7'd100));

  // R7
  pg_needs_sup_chk: assert property (@(posedge clk) disable iff (rst)
    pgood |-> sup_en);

  // R9
  pg_rise_cond_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pgood) |-> $past(at_90pct && !win_over && !win_under));
endmodule

bind ss_pg_sequencer ss_pg_sequencer_chk #(.NUM_STEPS(NUM_STEPS)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .supply_ok      (supply_ok),
  .en             (en),
  .win_over       (win_over),
  .win_under      (win_under),
  .at_90pct       (at_90pct),
  .ilim_pct       (ilim_pct),
  .toff_double    (toff_double),
  .first_low_pulse(first_low_pulse),
  .sup_en         (sup_en),
  .pgood          (pgood)
);

// File: tb/tb_ss_pg_sequencer.sv
`timescale 1ns/1ps
module tb_ss_pg_sequencer;
  localparam int DLY = 500;

  logic clk = 1'b0;
  logic rst, cyc_strobe, supply_ok, en, win_over, win_under, at_90pct;
  logic [6:0] ilim_pct;
  logic toff_double, ton_offset, first_low_pulse, sup_en, pgood;

  always #5 clk = ~clk;

  ss_pg_sequencer dut (
    .clk(clk), .rst(rst), .cyc_strobe(cyc_strobe), .supply_ok(supply_ok),
    .en(en), .win_over(win_over), .win_under(win_under), .at_90pct(at_90pct),
    .ilim_pct(ilim_pct), .toff_double(toff_double), .ton_offset(ton_offset),
    .first_low_pulse(first_low_pulse), .sup_en(sup_en), .pgood(pgood)
  );

  typedef struct {
    string req;
    int    pct;
    bit    toff, offs, first, sup, pg;
  } exp_t;

  exp_t exp_q[$];
  exp_t e;
  event exp_ev;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      cyc_strobe = 1'b1;
      @(negedge clk);
      cyc_strobe = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic expect_out(input string req);
    exp_t x;
    x = e;
    x.req = req;
    exp_q.push_back(x);
    -> exp_ev;
  endtask

  // monitor: pops expected items and compares against sampled outputs
  always @(exp_ev) begin
    while (exp_q.size() > 0) begin
      exp_t x;
      x = exp_q.pop_front();
      checks++;
      if (int'(ilim_pct) != x.pct || toff_double != x.toff || ton_offset != x.offs ||
          first_low_pulse != x.first || sup_en != x.sup || pgood != x.pg) begin
        errors++;
        $display("FAIL %s: got pct=%0d toff=%0b offs=%0b first=%0b sup=%0b pg=%0b exp pct=%0d toff=%0b offs=%0b first=%0b sup=%0b pg=%0b",
                 x.req, ilim_pct, toff_double, ton_offset, first_low_pulse, sup_en, pgood,
                 x.pct, x.toff, x.offs, x.first, x.sup, x.pg);
      end
    end
  end

  task automatic set_e(input int p, input bit t, input bit f, input bit s, input bit g);
    e.pct = p; e.toff = t; e.offs = t; e.first = f; e.sup = s; e.pg = g;
  endtask

  initial begin
    rst = 1; cyc_strobe = 0; supply_ok = 0; en = 0;
    win_over = 0; win_under = 1; at_90pct = 0;
    tick(3);
    rst = 0;
    tick(1);
    set_e(0, 0, 0, 0, 0);
    expect_out("R1 reset state");
    supply_ok = 1;
    tick(3);
    expect_out("R1 idle with en low");

    en = 1;
    tick(1);
    set_e(25, 1, 1, 0, 0);
    expect_out("R2 start values");
    strobes(1);
    e.first = 0;
    expect_out("R5 first pulse cleared");
    strobes(108);
    expect_out("R3 R4 still phase 1 at 109");
    strobes(1);
    set_e(50, 0, 0, 0, 0);
    expect_out("R3 R4 phase 2 at 110");
    strobes(110);
    e.pct = 75;
    expect_out("R3 phase 3 at 220");
    strobes(110);
    e.pct = 100;
    expect_out("R3 phase 4 at 330");

    win_under = 0; at_90pct = 1;
    tick(DLY + 50);
    expect_out("R7 pg low before sup_en");
    strobes(109);
    expect_out("R6 no sup at 439");
    strobes(1);
    e.sup = 1;
    expect_out("R6 sup at 440");
    tick(DLY - 3);
    expect_out("R9 pg not yet risen");
    tick(4);
    e.pg = 1;
    expect_out("R7 R9 pg risen");
    strobes(20);
    expect_out("R6 hold at 100");

    win_over = 1; tick(DLY / 2); win_over = 0; tick(DLY + 5);
    expect_out("R9 short excursion ignored");
    win_over = 1; tick(DLY - 3);
    expect_out("R9 fall not yet");
    tick(8);
    e.pg = 0;
    expect_out("R8 over-limit drops pg");
    win_over = 0; tick(DLY + 5);
    e.pg = 1;
    expect_out("R8 pg back in window");
    win_under = 1; at_90pct = 0; tick(DLY + 5);
    e.pg = 0;
    expect_out("R8 under-limit drops pg");
    win_under = 0; at_90pct = 1; tick(DLY + 5);
    e.pg = 1;
    expect_out("R8 pg recovers");

    supply_ok = 0;
    tick(1);
    set_e(0, 0, 0, 0, 0);
    expect_out("R1 R10 lockout clears");
    supply_ok = 1;
    tick(1);
    set_e(25, 1, 1, 0, 0);
    expect_out("R10 restart phase 1");
    strobes(50);
    en = 0;
    tick(1);
    set_e(0, 0, 0, 0, 0);
    expect_out("R1 disable clears");
    en = 1;
    tick(1);
    set_e(25, 1, 1, 0, 0);
    expect_out("R10 restart after disable");
    strobes(60);
    e.first = 0;
    expect_out("R10 count restarted");

    tick(2);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule